// File: doc/BRIEF.md
# I2C bus event regenerator

This block sits at the far end of a bus-extension link. It takes bus events (start, stop, data zero, data one) one at a time as tokens and rebuilds the matching waveform on a local I2C bus. It drives the bus only through open-drain enables: an enable of 1 pulls the line low, and 0 lets the pull-up raise it. The block has no view of the timing on the originating bus. Every phase length comes from a timing profile, and a 2-bit speed input picks that profile.

A data-zero level on SDA lasts only for a bounded hold-low interval. If no fresh token has arrived when that interval ends, the block lets SDA go, so the bus can never stall. When two zero bits are spaced apart, SDA can therefore rise for a short time while SCL is low. The I2C rules allow this, because the setup and hold spacing around every SCL edge is still met. Ones need no drive at all.

Top module: `i2c_event_regen`

## Requirements
- R1: After reset, scl_oe and sda_oe are 0 and ev_ready is 1.
- R2: For speed value s, with m = 2^(3-s), the phase counts in clock cycles are: SCL low 3m, SCL high 2m, setup m, hold m, and SDA hold-low limit 6m. These are the default bases shifted left by 3-s.
- R3: A START token (ev_code 0) accepted while scl_oe is 0 sets sda_oe at the accept edge. After the hold count it sets scl_oe. After a further hold count, ev_ready returns high.
- R4: A data token (ev_code 2 means zero, 3 means one) accepted while scl_oe is 1 sets sda_oe to the inverse of the bit at the accept edge. SCL then stays low for the low count, is released for the high count, and is pulled low again. SDA keeps its level for one more hold count before ev_ready returns.
- R5: A data-one token never sets sda_oe.
- R6: SDA is pulled low by a zero bit or by a START. Once the hold-low limit has elapsed and the block is waiting for a token, SDA is released unless a new token is accepted in that same cycle. So zero bits sent back to back keep SDA low, and zero bits with a gap between them show a release.
- R7: A START token accepted while scl_oe is 1 (a repeated start) works as follows. It releases SDA with SCL low for the low count, then releases SCL for the setup count, then pulls SDA low for the hold count, then pulls SCL low and waits a hold count.
- R8: A STOP token (ev_code 1) accepted while scl_oe is 1 pulls SDA low with SCL low for the low count. It then releases SCL for the setup count, then releases SDA and returns to idle.
- R9: STOP and data tokens accepted while scl_oe is 0 have no effect on either line, and ev_ready stays high.
- R10: A token is taken only on a clock edge with ev_valid and ev_ready both high. ev_ready is low from the edge after acceptance until the bus phase sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed | input | 2 | Timing profile select |
| ev_valid | input | 1 | Event token present |
| ev_code | input | 2 | Event: 0 start, 1 stop, 2 data zero, 3 data one |
| ev_ready | output | 1 | Block can take a token |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A wrong phase counter shows at the ports as an SCL low or high stretch of the wrong length. It is seen at the first cycle where the edge comes early or late, within one token. A stale hold-low timer leaves SDA low past the limit, or lets it go in the cycle a back-to-back zero bit is accepted. Both show within one bit time of the token that follows. A wrong view of whether a frame is open makes a stop or data token on a free bus move a line, and that shows in the cycle after acceptance.

// File: rtl/i2c_event_regen.sv
module i2c_event_regen #(
  parameter int LOW_BASE  = 3,
  parameter int HIGH_BASE = 2,
  parameter int SU_BASE   = 1,
  parameter int HD_BASE   = 1,
  parameter int HOLD_BASE = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] speed,
  input  logic       ev_valid,
  input  logic [1:0] ev_code,
  output logic       ev_ready,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int MAXB = (LOW_BASE > HOLD_BASE) ?
                        ((LOW_BASE > HIGH_BASE) ? LOW_BASE : HIGH_BASE) :
                        ((HOLD_BASE > HIGH_BASE) ? HOLD_BASE : HIGH_BASE);
  localparam int CW   = $clog2(MAXB * 8 + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RSL, S_RSH, S_STH, S_BL, S_BH, S_POST, S_SPL, S_SPS
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt, hold;
  logic          scl_q, sda_q;
  logic [1:0]    sh;
  logic [CW-1:0] t_low, t_high, t_su, t_hd, t_hold;

  assign sh     = 2'd3 - speed;
  assign t_low  = CW'(LOW_BASE  << sh);
  assign t_high = CW'(HIGH_BASE << sh);
  assign t_su   = CW'(SU_BASE   << sh);
  assign t_hd   = CW'(HD_BASE   << sh);
  assign t_hold = CW'(HOLD_BASE << sh);

  assign ev_ready = (st == S_IDLE);
  assign scl_oe   = scl_q;
  assign sda_oe   = sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      hold  <= '0;
      scl_q <= 1'b0;
      sda_q <= 1'b0;
    end else begin
      if (hold != '0) hold <= hold - 1'b1;
      if (st == S_IDLE) begin
        if (ev_valid) begin
          case (ev_code)
            2'd0: begin
              if (scl_q) begin
                sda_q <= 1'b0;
                cnt   <= t_low - 1'b1;
                st    <= S_RSL;
              end else begin
                sda_q <= 1'b1;
                hold  <= t_hold - 1'b1;
                cnt   <= t_hd - 1'b1;
                st    <= S_STH;
              end
            end
            2'd1: begin
              if (scl_q) begin
                sda_q <= 1'b1;
                cnt   <= t_low - 1'b1;
                st    <= S_SPL;
              end
            end
            default: begin
              if (scl_q) begin
                sda_q <= ~ev_code[0];
                hold  <= t_hold - 1'b1;
                cnt   <= t_low - 1'b1;
                st    <= S_BL;
              end
            end
          endcase
        end else if (sda_q && hold == '0) begin
          sda_q <= 1'b0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          S_RSL: begin
            scl_q <= 1'b0;
            cnt   <= t_su - 1'b1;
            st    <= S_RSH;
          end
          S_RSH: begin
            sda_q <= 1'b1;
            hold  <= t_hold - 1'b1;
            cnt   <= t_hd - 1'b1;
            st    <= S_STH;
          end
          S_STH: begin
            scl_q <= 1'b1;
            cnt   <= t_hd - 1'b1;
            st    <= S_POST;
          end
          S_BL: begin
            scl_q <= 1'b0;
            cnt   <= t_high - 1'b1;
            st    <= S_BH;
          end
          S_BH: begin
            scl_q <= 1'b1;
            cnt   <= t_hd - 1'b1;
            st    <= S_POST;
          end
          S_SPL: begin
            scl_q <= 1'b0;
            cnt   <= t_su - 1'b1;
            st    <= S_SPS;
          end
          S_SPS: begin
            sda_q <= 1'b0;
            st    <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r3_start_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && ev_code == 2'd0 && !scl_oe) |=> (sda_oe && !scl_oe && !ev_ready));

  a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BH) |=> $stable(sda_oe));

  a_r6_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ready && !ev_valid && sda_oe && hold == '0) |=> !sda_oe);

  a_r7_rs_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RSH) |-> (!scl_oe && !sda_oe));

  a_r8_stop_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SPS) |-> (!scl_oe && sda_oe));

  a_r9_free_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ready && !scl_oe) |-> !sda_oe);
endmodule

// File: tb/sim_i2c_event_regen.sv
module sim_i2c_event_regen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] speed = 2'd3;
  logic       ev_valid = 1'b0;
  logic [1:0] ev_code = 2'd0;
  logic       ev_ready, scl_oe, sda_oe;
  int         n_run = 0, n_fail = 0;
  bit         in_frame = 1'b0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  i2c_event_regen u0 (
    .clk(clk), .rst_n(rst_n), .speed(speed), .ev_valid(ev_valid),
    .ev_code(ev_code), .ev_ready(ev_ready), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // ops: 0 start free, 1 repeated start, 2 stop in frame, 3 stop free,
  //      4 data zero, 5 data one, 6 data on free bus
  function automatic int busy_len(int op, int m);
    case (op)
      0: return 2*m;
      1: return 3*m + m + 2*m;
      2: return 3*m + m;
      4, 5: return 3*m + 2*m + m;
      default: return 0;
    endcase
  endfunction

  function automatic logic [2:0] expect_at(int op, int k, int m);
    int L = 3*m, H = 2*m, S = m, D = m, HL = 6*m, B, rel;
    logic rdy, scl, sda;
    B = busy_len(op, m);
    rdy = (k >= B);
    scl = 1'b0; sda = 1'b0;
    case (op)
      0: begin
        scl = (k >= D);
        rel = (2*D+1 > HL) ? 2*D+1 : HL;
        sda = (k < rel);
      end
      1: begin
        scl = (k < L) || (k >= L+S+D);
        rel = (L+S+2*D+1 > L+S+HL) ? L+S+2*D+1 : L+S+HL;
        sda = (k >= L+S) && (k < rel);
      end
      2: begin
        scl = (k < L);
        sda = (k < L+S);
      end
      4, 5: begin
        scl = (k < L) || (k >= L+H);
        rel = (B+1 > HL) ? B+1 : HL;
        sda = (op == 4) && (k < rel);
      end
      default: begin
        scl = 1'b0; sda = 1'b0;
      end
    endcase
    return {rdy, scl, sda};
  endfunction

  task automatic run_op(input logic [1:0] code, input int extra, input int m);
    int op, kmax;
    logic [2:0] got, exp;
    string tag;
    case (code)
      2'd0: begin op = in_frame ? 1 : 0; tag = in_frame ? "R7" : "R3 R2"; in_frame = 1'b1; end
      2'd1: begin op = in_frame ? 2 : 3; tag = in_frame ? "R8" : "R9"; in_frame = 1'b0; end
      default: begin
        op  = in_frame ? (code[0] ? 5 : 4) : 6;
        tag = in_frame ? (code[0] ? "R5 R4" : "R4 R6") : "R9";
      end
    endcase
    kmax = busy_len(op, m) + extra;
    ev_code  = code;
    ev_valid = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
    for (int k = 0; k < kmax; k++) begin
      got = {ev_ready, scl_oe, sda_oe};
      exp = expect_at(op, k, m);
      n_run++;
      if (got !== exp) begin
        n_fail++;
        $display("FAIL %s%s speed=%0d op=%0d k=%0d {rdy,scl,sda} actual %b expected %b",
                 tag, (got[2] !== exp[2]) ? " R10" : "", speed, op, k, got, exp);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if ({ev_ready, scl_oe, sda_oe} !== 3'b100) begin
      n_fail++;
      $display("FAIL R1 reset actual %b expected 100", {ev_ready, scl_oe, sda_oe});
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 3; s >= 0; s--) begin
      int m;
      speed = 2'(s);
      m = 1 << (3 - s);
      run_op(2'd0, 0, m);        // R3 start, tight follow-up
      run_op(2'd2, 0, m);        // R6 back-to-back zeros stay low
      run_op(2'd2, 3, m);        // R6 gap: release after hold limit
      run_op(2'd3, 2, m);        // R5
      run_op(2'd2, 0, m);
      run_op(2'd0, 6*m, m);      // R7 repeated start
      run_op(2'd3, 0, m);
      run_op(2'd1, 2, m);        // R8
      run_op(2'd1, 3, m);        // R9 stop on free bus
      run_op(2'd2, 3, m);        // R9 data on free bus
      run_op(2'd3, 3, m);        // R9
      run_op(2'd0, 6*m + 2, m);  // R3 start, hold-limit release
      run_op(2'd1, 2, m);
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule